// File: doc/BRIEF.md
# Thread Block Admission Allocator

This block sits in front of one multiprocessor and decides when an incoming thread-block launch may become resident. Each request states how many threads the block has, how many registers each of its threads needs and how many bytes of shared memory it wants. The allocator weighs that request against four limits at once: resident-block slots, resident threads, the register pool and shared memory. When all four have room, it picks a slot, stores what the block consumes in that slot's record, and returns the slot number together with the number of 32-thread warps the block occupies.

Requests are taken strictly one at a time and in arrival order. A request that does not fit yet stays at the head and holds the request port closed until finished blocks return enough resources. A finished block is returned by naming its slot on the release port, which gives back exactly what was recorded for that slot. A request that could never fit, even on an empty multiprocessor, is dropped and flagged.

The control is a three-state machine. `ST_IDLE` keeps `req_ready` high and moves to `ST_CHECK` when a request is taken. `ST_CHECK` evaluates the captured request every cycle: the *reject* transition returns to `ST_IDLE` with a one-cycle error pulse, the *admit* transition records the block and moves to `ST_GRANT`, and the *stall* transition stays in `ST_CHECK`. `ST_GRANT` holds `grant_valid` until `grant_ready` is seen, then the *handoff* transition returns to `ST_IDLE`.

Top module: `blk_admit_alloc`

## Requirements
- R1: After reset, `req_ready` is 1, `grant_valid` is 0, `err_drop` is 0, and no slot, thread, register or shared memory is in use.
- R2: `grant_warps` equals the thread count divided by 32, rounded up (1 thread gives 1, 32 give 1, 33 give 2, 256 give 8, 768 give 24).
- R3: At most 8 blocks are resident; a ninth request waits with no grant until a slot is released.
- R4: The resident thread total never exceeds 768: three 256-thread blocks or six 128-thread blocks are admitted together, and a further block that would pass 768 waits with `req_ready` low.
- R5: The sum over resident blocks of threads times registers per thread never exceeds 8192; a block that would pass it waits.
- R6: The sum of resident shared memory bytes never exceeds 16384; a block that would pass it waits.
- R7: Requests are admitted in arrival order: while the head request waits, `req_ready` stays low, and a later request is granted only after the head.
- R8: A release of slot s returns exactly the threads, registers and bytes recorded for s and frees s; a release naming a slot that holds no block has no effect.
- R9: A release and an admission check in the same cycle see the released resources, so a waiting request that fits once the release is counted is granted on that same clock edge.
- R10: A request with zero threads, more than 768 threads, more than 8192 registers in total, or more than 16384 bytes raises `err_drop` for exactly one cycle, two edges after it is taken, is discarded without a grant, and leaves the resources unchanged.
- R11: The granted slot is the lowest-numbered free slot, and `grant_valid`, `grant_slot` and `grant_warps` hold steady until `grant_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Allocator can take a request |
| req_threads | input | 11 | Threads in the requested block |
| req_regs | input | 8 | Registers needed by each thread |
| req_smem | input | 16 | Shared memory bytes for the block |
| grant_valid | output | 1 | A block has been admitted |
| grant_ready | input | 1 | Consumer takes the grant |
| grant_slot | output | 3 | Slot assigned to the admitted block |
| grant_warps | output | 5 | Warps the admitted block occupies |
| rel_valid | input | 1 | A resident block has finished |
| rel_slot | input | 3 | Slot of the finished block |
| err_drop | output | 1 | One-cycle pulse for a request that can never fit |

## Verification
The bench drives each limit to exactly full and then one unit past it, so a comparison written with the wrong strictness either refuses a block that fills a resource to the brim or lets one overflow it. It keeps a waiting request at the head while a second request is offered, which exposes a design that reorders or lets the later request slip in. It releases a slot in the same cycle as a waiting check and samples right after that edge, where a design that applies the release late grants one cycle too late. It also releases an empty slot and then refills to capacity, which catches accounting that underflows or double-returns, and it sends impossible requests to confirm they pulse the error flag and leave no trace.

// File: rtl/bta_pkg.sv
package bta_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_GRANT
    } adm_state_t;

endpackage

// File: rtl/bta_slot_table.sv
module bta_slot_table #(
    parameter int SLOTS = 8,
    parameter int SLW   = 3,
    parameter int UTW   = 10,
    parameter int URW   = 14,
    parameter int USW   = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [SLW-1:0]   alloc_slot,
    input  logic [UTW-1:0]   alloc_thr,
    input  logic [URW-1:0]   alloc_reg,
    input  logic [USW-1:0]   alloc_smem,
    input  logic             rel_en,
    input  logic [SLW-1:0]   rel_slot,
    output logic [SLOTS-1:0] avail,
    output logic             rel_hit,
    output logic [UTW-1:0]   rel_thr,
    output logic [URW-1:0]   rel_reg,
    output logic [USW-1:0]   rel_smem
);

    logic [SLOTS-1:0] busy_q;
    logic [SLOTS-1:0] alloc_sel;
    logic [SLOTS-1:0] rel_sel;
    logic [UTW-1:0]   thr_q  [SLOTS];
    logic [URW-1:0]   reg_q  [SLOTS];
    logic [USW-1:0]   smem_q [SLOTS];

    // One-hot decode of the two slot ports, one lane per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_sel
        assign alloc_sel[g] = alloc_en && (alloc_slot == SLW'(g));
        assign rel_sel[g]   = rel_en && (rel_slot == SLW'(g)) && busy_q[g];
    end

    assign rel_hit  = |rel_sel;
    assign rel_thr  = rel_hit ? thr_q[rel_slot]  : '0;
    assign rel_reg  = rel_hit ? reg_q[rel_slot]  : '0;
    assign rel_smem = rel_hit ? smem_q[rel_slot] : '0;

    // A slot being released this cycle counts as free for the check.
    assign avail = ~busy_q | rel_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                thr_q[i]  <= '0;
                reg_q[i]  <= '0;
                smem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (alloc_sel[i]) begin
                    busy_q[i] <= 1'b1;
                    thr_q[i]  <= alloc_thr;
                    reg_q[i]  <= alloc_reg;
                    smem_q[i] <= alloc_smem;
                end else if (rel_sel[i]) begin
                    busy_q[i] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/bta_usage_acct.sv
module bta_usage_acct #(
    parameter int UTW = 10,
    parameter int URW = 14,
    parameter int USW = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_en,
    input  logic [UTW-1:0] alloc_thr,
    input  logic [URW-1:0] alloc_reg,
    input  logic [USW-1:0] alloc_smem,
    input  logic [UTW-1:0] rel_thr,
    input  logic [URW-1:0] rel_reg,
    input  logic [USW-1:0] rel_smem,
    output logic [UTW-1:0] used_thr,
    output logic [URW-1:0] used_reg,
    output logic [USW-1:0] used_smem
);

    // Release amounts arrive already masked to zero when no slot is freed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_thr  <= '0;
            used_reg  <= '0;
            used_smem <= '0;
        end else begin
            used_thr  <= used_thr  - rel_thr  + (alloc_en ? alloc_thr  : '0);
            used_reg  <= used_reg  - rel_reg  + (alloc_en ? alloc_reg  : '0);
            used_smem <= used_smem - rel_smem + (alloc_en ? alloc_smem : '0);
        end
    end

endmodule

// File: rtl/bta_fit_eval.sv
module bta_fit_eval #(
    parameter int SLOTS      = 8,
    parameter int SLW        = 3,
    parameter int THREAD_CAP = 768,
    parameter int REG_POOL   = 8192,
    parameter int SMEM_BYTES = 16384,
    parameter int WARP_SIZE  = 32,
    parameter int TW         = 11,
    parameter int RPT_W      = 8,
    parameter int SW         = 16,
    parameter int UTW        = 10,
    parameter int URW        = 14,
    parameter int USW        = 15,
    parameter int WW         = 5
) (
    input  logic [TW-1:0]    req_thr,
    input  logic [RPT_W-1:0] req_rpt,
    input  logic [SW-1:0]    req_smem,
    input  logic [UTW-1:0]   used_thr,
    input  logic [URW-1:0]   used_reg,
    input  logic [USW-1:0]   used_smem,
    input  logic [UTW-1:0]   rel_thr,
    input  logic [URW-1:0]   rel_reg,
    input  logic [USW-1:0]   rel_smem,
    input  logic [SLOTS-1:0] avail,
    output logic             never_fits,
    output logic             fits,
    output logic [SLW-1:0]   free_slot,
    output logic [UTW-1:0]   need_thr,
    output logic [URW-1:0]   need_reg,
    output logic [USW-1:0]   need_smem,
    output logic [WW-1:0]    need_warps
);

    logic [31:0] thr_w, reg_w, smem_w;
    logic [31:0] base_thr, base_reg, base_smem;
    logic        slot_found;

    assign thr_w  = 32'(req_thr);
    assign reg_w  = 32'(req_thr) * 32'(req_rpt);
    assign smem_w = 32'(req_smem);

    // Occupancy after this cycle's release has been taken out.
    assign base_thr  = 32'(used_thr)  - 32'(rel_thr);
    assign base_reg  = 32'(used_reg)  - 32'(rel_reg);
    assign base_smem = 32'(used_smem) - 32'(rel_smem);

    assign never_fits = (thr_w == 32'd0)
                     || (thr_w  > 32'(THREAD_CAP))
                     || (reg_w  > 32'(REG_POOL))
                     || (smem_w > 32'(SMEM_BYTES));

    // Lowest-numbered free slot.
    always_comb begin
        slot_found = 1'b0;
        free_slot  = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (avail[i]) begin
                slot_found = 1'b1;
                free_slot  = SLW'(i);
            end
        end
    end

    assign fits = slot_found
               && ((base_thr  + thr_w)  <= 32'(THREAD_CAP))
               && ((base_reg  + reg_w)  <= 32'(REG_POOL))
               && ((base_smem + smem_w) <= 32'(SMEM_BYTES));

    assign need_thr   = UTW'(thr_w);
    assign need_reg   = URW'(reg_w);
    assign need_smem  = USW'(smem_w);
    assign need_warps = WW'((thr_w + 32'(WARP_SIZE) - 32'd1) / 32'(WARP_SIZE));

endmodule

// File: rtl/blk_admit_alloc.sv
module blk_admit_alloc #(
    parameter int SLOTS      = 8,
    parameter int THREAD_CAP = 768,
    parameter int REG_POOL   = 8192,
    parameter int SMEM_BYTES = 16384,
    parameter int WARP_SIZE  = 32,
    parameter int RPT_W      = 8,
    localparam int TW        = $clog2(THREAD_CAP + 1) + 1,
    localparam int SW        = $clog2(SMEM_BYTES + 1) + 1,
    localparam int SLW       = $clog2(SLOTS),
    localparam int MAX_WARPS = (THREAD_CAP + WARP_SIZE - 1) / WARP_SIZE,
    localparam int WW        = $clog2(MAX_WARPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [TW-1:0]    req_threads,
    input  logic [RPT_W-1:0] req_regs,
    input  logic [SW-1:0]    req_smem,
    output logic             grant_valid,
    input  logic             grant_ready,
    output logic [SLW-1:0]   grant_slot,
    output logic [WW-1:0]    grant_warps,
    input  logic             rel_valid,
    input  logic [SLW-1:0]   rel_slot,
    output logic             err_drop
);

    import bta_pkg::*;

    localparam int UTW = $clog2(THREAD_CAP + 1);
    localparam int URW = $clog2(REG_POOL + 1);
    localparam int USW = $clog2(SMEM_BYTES + 1);

    adm_state_t state_q, state_d;

    logic [TW-1:0]    hold_thr_q;
    logic [RPT_W-1:0] hold_rpt_q;
    logic [SW-1:0]    hold_smem_q;
    logic [SLW-1:0]   slot_q;
    logic [WW-1:0]    warps_q;
    logic             err_q;

    logic [SLOTS-1:0] avail;
    logic             rel_hit;
    logic [UTW-1:0]   rel_thr, used_thr, need_thr;
    logic [URW-1:0]   rel_reg, used_reg, need_reg;
    logic [USW-1:0]   rel_smem, used_smem, need_smem;
    logic [SLW-1:0]   free_slot;
    logic [WW-1:0]    need_warps;
    logic             never_fits, fits, alloc_en;

    assign alloc_en = (state_q == ST_CHECK) && !never_fits && fits;

    bta_fit_eval #(
        .SLOTS(SLOTS), .SLW(SLW), .THREAD_CAP(THREAD_CAP), .REG_POOL(REG_POOL),
        .SMEM_BYTES(SMEM_BYTES), .WARP_SIZE(WARP_SIZE), .TW(TW), .RPT_W(RPT_W),
        .SW(SW), .UTW(UTW), .URW(URW), .USW(USW), .WW(WW)
    ) u_fit (
        .req_thr   (hold_thr_q),
        .req_rpt   (hold_rpt_q),
        .req_smem  (hold_smem_q),
        .used_thr  (used_thr),
        .used_reg  (used_reg),
        .used_smem (used_smem),
        .rel_thr   (rel_thr),
        .rel_reg   (rel_reg),
        .rel_smem  (rel_smem),
        .avail     (avail),
        .never_fits(never_fits),
        .fits      (fits),
        .free_slot (free_slot),
        .need_thr  (need_thr),
        .need_reg  (need_reg),
        .need_smem (need_smem),
        .need_warps(need_warps)
    );

    bta_slot_table #(
        .SLOTS(SLOTS), .SLW(SLW), .UTW(UTW), .URW(URW), .USW(USW)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_slot(free_slot),
        .alloc_thr (need_thr),
        .alloc_reg (need_reg),
        .alloc_smem(need_smem),
        .rel_en    (rel_valid),
        .rel_slot  (rel_slot),
        .avail     (avail),
        .rel_hit   (rel_hit),
        .rel_thr   (rel_thr),
        .rel_reg   (rel_reg),
        .rel_smem  (rel_smem)
    );

    bta_usage_acct #(
        .UTW(UTW), .URW(URW), .USW(USW)
    ) u_acct (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_thr (need_thr),
        .alloc_reg (need_reg),
        .alloc_smem(need_smem),
        .rel_thr   (rel_thr),
        .rel_reg   (rel_reg),
        .rel_smem  (rel_smem),
        .used_thr  (used_thr),
        .used_reg  (used_reg),
        .used_smem (used_smem)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (never_fits) state_d = ST_IDLE;
                else if (fits)  state_d = ST_GRANT;
            end
            ST_GRANT: begin
                if (grant_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured request / grant data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            hold_thr_q  <= '0;
            hold_rpt_q  <= '0;
            hold_smem_q <= '0;
            slot_q      <= '0;
            warps_q     <= '0;
            err_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= (state_q == ST_CHECK) && never_fits;
            if (state_q == ST_IDLE && req_valid) begin
                hold_thr_q  <= req_threads;
                hold_rpt_q  <= req_regs;
                hold_smem_q <= req_smem;
            end
            if (alloc_en) begin
                slot_q  <= free_slot;
                warps_q <= need_warps;
            end
        end
    end

    // Outputs.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        grant_valid = (state_q == ST_GRANT);
        grant_slot  = slot_q;
        grant_warps = warps_q;
        err_drop    = err_q;
    end

endmodule

// File: rtl/bta_admit_checker.sv
module bta_admit_checker #(
    parameter int THREAD_CAP = 768,
    parameter int REG_POOL   = 8192,
    parameter int SMEM_BYTES = 16384,
    parameter int MAX_WARPS  = 24,
    parameter int SLW        = 3,
    parameter int WW         = 5,
    parameter int UTW        = 10,
    parameter int URW        = 14,
    parameter int USW        = 15
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_ready,
    input logic           grant_valid,
    input logic           grant_ready,
    input logic [SLW-1:0] grant_slot,
    input logic [WW-1:0]  grant_warps,
    input logic           err_drop,
    input logic [UTW-1:0] used_thr,
    input logic [URW-1:0] used_reg,
    input logic [USW-1:0] used_smem
);

    AST_WARPS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_warps >= WW'(1)) && (32'(grant_warps) <= 32'(MAX_WARPS))); // R2

    AST_THREAD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        32'(used_thr) <= 32'(THREAD_CAP)); // R4

    AST_REG_POOL: assert property (@(posedge clk) disable iff (!rst_n)
        32'(used_reg) <= 32'(REG_POOL)); // R5

    AST_SMEM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        32'(used_smem) <= 32'(SMEM_BYTES)); // R6

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_drop |=> !err_drop); // R10

    AST_ERR_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        err_drop |-> (!grant_valid && req_ready)); // R10

    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !grant_ready) |=> (grant_valid && $stable(grant_slot) && $stable(grant_warps))); // R11

endmodule

bind blk_admit_alloc bta_admit_checker #(
    .THREAD_CAP(THREAD_CAP),
    .REG_POOL  (REG_POOL),
    .SMEM_BYTES(SMEM_BYTES),
    .MAX_WARPS (MAX_WARPS),
    .SLW       (SLW),
    .WW        (WW),
    .UTW       (UTW),
    .URW       (URW),
    .USW       (USW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .grant_valid(grant_valid),
    .grant_ready(grant_ready),
    .grant_slot (grant_slot),
    .grant_warps(grant_warps),
    .err_drop   (err_drop),
    .used_thr   (used_thr),
    .used_reg   (used_reg),
    .used_smem  (used_smem)
);

// File: tb/blk_admit_alloc_test.sv
module blk_admit_alloc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [10:0] req_threads = '0;
    logic [7:0]  req_regs = '0;
    logic [15:0] req_smem = '0;
    logic        grant_valid;
    logic        grant_ready = 1'b0;
    logic [2:0]  grant_slot;
    logic [4:0]  grant_warps;
    logic        rel_valid = 1'b0;
    logic [2:0]  rel_slot = '0;
    logic        err_drop;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    blk_admit_alloc uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_threads(req_threads), .req_regs(req_regs), .req_smem(req_smem),
        .grant_valid(grant_valid), .grant_ready(grant_ready),
        .grant_slot(grant_slot), .grant_warps(grant_warps),
        .rel_valid(rel_valid), .rel_slot(rel_slot),
        .err_drop(err_drop)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic send_req(input int thr, input int rpt, input int smem);
        req_threads = 11'(thr);
        req_regs    = 8'(rpt);
        req_smem    = 16'(smem);
        req_valid   = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_grant(input string tag, input int slot, input int warps);
        int n = 0;
        while (!grant_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        check({tag, " grant_valid"}, int'(grant_valid), 1);
        check({tag, " grant_slot"}, int'(grant_slot), slot);
        check({tag, " grant_warps"}, int'(grant_warps), warps);
        grant_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        grant_ready = 1'b0;
    endtask

    task automatic release_slot(input int slot);
        rel_valid = 1'b1;
        rel_slot  = 3'(slot);
        @(posedge clk);
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic release_all();
        for (int s = 0; s < 8; s++) release_slot(s);
    endtask

    task automatic expect_stall(input string tag);
        repeat (4) @(negedge clk);
        check({tag, " stall grant_valid"}, int'(grant_valid), 0);
        check({tag, " stall req_ready"}, int'(req_ready), 0);
    endtask

    task automatic admit(input string tag, input int thr, input int rpt, input int smem,
                         input int slot, input int warps);
        send_req(thr, rpt, smem);
        expect_grant(tag, slot, warps);
    endtask

    task automatic t_reset();
        check("R1 req_ready", int'(req_ready), 1);
        check("R1 grant_valid", int'(grant_valid), 0);
        check("R1 err_drop", int'(err_drop), 0);
        admit("R1 full-size block on empty", 768, 10, 16384, 0, 24);
        release_all();
    endtask

    task automatic t_warps();
        admit("R2 33 threads", 33, 1, 0, 0, 2);
        admit("R2 32 threads", 32, 1, 0, 1, 1);
        admit("R2 1 thread", 1, 1, 0, 2, 1);
        admit("R2 100 threads", 100, 1, 0, 3, 4);
        release_all();
    endtask

    task automatic t_slots();
        for (int i = 0; i < 8; i++) admit("R3 fill", 32, 1, 0, i, 1);
        send_req(32, 1, 0);
        expect_stall("R3 ninth block");
        release_slot(5);
        expect_grant("R3 after release", 5, 1);
        release_all();
    endtask

    task automatic t_threads();
        for (int i = 0; i < 3; i++) admit("R4 256x3", 256, 1, 0, i, 8);
        send_req(256, 1, 0);
        expect_stall("R4 fourth 256");
        release_slot(1);
        expect_grant("R4 after release", 1, 8);
        release_all();
        for (int i = 0; i < 6; i++) admit("R4 128x6", 128, 1, 0, i, 4);
        release_all();
    endtask

    task automatic t_regs();
        admit("R5 4096 regs a", 256, 16, 0, 0, 8);
        admit("R5 4096 regs b", 256, 16, 0, 1, 8);
        send_req(1, 1, 0);
        expect_stall("R5 pool exhausted");
        release_slot(0);
        expect_grant("R5 after release", 0, 1);
        release_all();
    endtask

    task automatic t_smem();
        admit("R6 8192 bytes a", 32, 1, 8192, 0, 1);
        admit("R6 8192 bytes b", 32, 1, 8192, 1, 1);
        send_req(32, 1, 1);
        expect_stall("R6 one byte over");
        release_slot(1);
        expect_grant("R6 after release", 1, 1);
        release_all();
    endtask

    task automatic t_order();
        for (int i = 0; i < 3; i++) admit("R7 fill", 256, 1, 0, i, 8);
        send_req(256, 1, 0);
        // second request offered behind the waiting head
        req_threads = 11'd32;
        req_regs    = 8'd1;
        req_smem    = 16'd0;
        req_valid   = 1'b1;
        expect_stall("R7 head waits");
        release_slot(2);
        expect_grant("R7 head first", 2, 8);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        expect_stall("R7 later request");
        release_slot(0);
        expect_grant("R7 later second", 0, 1);
        release_all();
    endtask

    task automatic t_release();
        release_slot(3);
        for (int i = 0; i < 3; i++) admit("R8 refill after idle release", 256, 1, 0, i, 8);
        release_slot(1);
        send_req(257, 1, 0);
        expect_stall("R8 no over-return");
        release_slot(0);
        expect_grant("R8 exact return", 0, 9);
        release_all();
    endtask

    task automatic t_same_cycle();
        for (int i = 0; i < 3; i++) admit("R9 fill", 256, 1, 0, i, 8);
        send_req(256, 1, 0);
        expect_stall("R9 waiting");
        release_slot(0);
        check("R9 grant same edge", int'(grant_valid), 1);
        expect_grant("R9 reused slot", 0, 8);
        release_all();
    endtask

    task automatic t_reject(input string tag, input int thr, input int rpt, input int smem);
        send_req(thr, rpt, smem);
        @(negedge clk);
        check({tag, " err_drop"}, int'(err_drop), 1);
        check({tag, " no grant"}, int'(grant_valid), 0);
        check({tag, " ready again"}, int'(req_ready), 1);
        @(negedge clk);
        check({tag, " err one cycle"}, int'(err_drop), 0);
    endtask

    task automatic t_grant_hold();
        send_req(64, 2, 100);
        repeat (3) @(negedge clk);
        check("R11 held valid", int'(grant_valid), 1);
        repeat (4) @(negedge clk);
        check("R11 still valid", int'(grant_valid), 1);
        check("R11 slot steady", int'(grant_slot), 0);
        check("R11 warps steady", int'(grant_warps), 2);
        expect_grant("R11 consume", 0, 2);
        check("R11 dropped after ready", int'(grant_valid), 0);
        release_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_warps();
        t_slots();
        t_threads();
        t_regs();
        t_smem();
        t_order();
        t_release();
        t_same_cycle();
        t_reject("R10 too many threads", 769, 1, 0);
        t_reject("R10 too many regs", 256, 33, 0);
        t_reject("R10 too much smem", 32, 1, 16385);
        t_reject("R10 zero threads", 0, 1, 0);
        admit("R10 nothing retained", 768, 10, 16384, 0, 24);
        release_all();
        t_grant_hold();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule